// File: doc/BRIEF.md
# Current and Power Result Calculator

This block turns one averaged shunt-voltage sample and one bus-voltage sample into a current result and a power result. The current is the product of the signed shunt sample and a programmed unsigned calibration factor. It is clamped into a signed 12-bit field that sits left-justified in a 16-bit word, with the four low bits at zero. The power is the product of the current magnitude and the bus sample. It is clamped to an unsigned 16-bit word.

A one-cycle start pulse captures all three operands. The computation then runs over a fixed number of cycles and ends with a one-cycle done pulse, which a conversion-ready stage can consume. When the current or the power is clamped, an overflow flag is raised to mark the results as suspect. The results and the flag keep their values until the next computation completes.

Top module: `cpc_calc`

## Requirements
- R1: After reset, `cur_o`, `pwr_o`, `ovf_o`, `busy_o` and `done_o` are all 0.
- R2: A start pulse sampled while `busy_o` is low sets `busy_o` for the next two cycles. `done_o` is then high for exactly one cycle, the third cycle after the start edge, and `busy_o` is low in that cycle.
- R3: When shunt×cal lies within [-2048, 2047], `cur_o[15:4]` holds that product in two's complement and `cur_o[3:0]` is 0.
- R4: A shunt×cal product above 2047 gives 2047, and one below -2048 gives -2048. In both cases `ovf_o` is 1.
- R5: `pwr_o` equals |current|×bus, where current is the value after clamping. A negative current therefore gives a non-negative power, and a current of 0 gives a power of 0.
- R6: A power product above 65535 gives `pwr_o` = 65535 and sets `ovf_o`.
- R7: `ovf_o` reflects only the most recently completed computation. A computation in which neither result is clamped clears it.
- R8: A start pulse while `busy_o` is high is ignored. Changes to the operand inputs after the start edge do not affect the results.
- R9: A calibration value of 0 gives a current of 0 and a power of 0, with `ovf_o` = 0.
- R10: `cur_o`, `pwr_o` and `ovf_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the operands |
| shunt_i | input | 12 | Shunt sample, two's complement |
| bus_i | input | 11 | Bus sample, unsigned |
| cal_i | input | 15 | Calibration factor, unsigned |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cur_o | output | 16 | Current, signed field in bits 15:4 |
| pwr_o | output | 16 | Power, unsigned |
| ovf_o | output | 1 | A result of the last computation was clamped |

## Verification
The bench builds the block with its default widths: a 12-bit shunt sample, an 11-bit bus sample, a 15-bit calibration factor and 16-bit outputs. At these widths every clamp boundary can be reached with operands that fit in a machine integer. This covers a current of exactly -2048 without overflow, -2048 reached by clamping, 2047 at both edges, and a power clamp driven by a full-scale current against a full-scale bus. Random operands, skewed toward small calibration factors, exercise the in-range products, and directed runs cover a zero calibration factor, a start pulse during a busy window, and operand changes after the start edge.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CUR  = 2'd1,
        ST_PWR  = 2'd2
    } cpc_state_e;
endpackage

// File: rtl/cpc_cur_unit.sv
module cpc_cur_unit #(
    parameter int SW = 12,
    parameter int CW = 15
) (
    input  logic signed [SW-1:0] shunt_i,
    input  logic        [CW-1:0] cal_i,
    output logic signed [SW-1:0] cur_o,
    output logic                 ovf_o
);
    localparam int PW = SW + CW + 1;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] hi_lim;
    logic signed [PW-1:0] lo_lim;

    always_comb begin
        a_ext  = {{(PW-SW){shunt_i[SW-1]}}, shunt_i};
        b_ext  = {{(PW-CW){1'b0}}, cal_i};
        prod   = a_ext * b_ext;
        hi_lim = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
        lo_lim = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};
        if (prod > hi_lim) begin
            cur_o = {1'b0, {(SW-1){1'b1}}};
            ovf_o = 1'b1;
        end else if (prod < lo_lim) begin
            cur_o = {1'b1, {(SW-1){1'b0}}};
            ovf_o = 1'b1;
        end else begin
            cur_o = prod[SW-1:0];
            ovf_o = 1'b0;
        end
    end
endmodule

// File: rtl/cpc_pwr_unit.sv
module cpc_pwr_unit #(
    parameter int SW    = 12,
    parameter int BW    = 11,
    parameter int PWR_W = 16
) (
    input  logic signed [SW-1:0]    cur_i,
    input  logic        [BW-1:0]    bus_i,
    output logic        [PWR_W-1:0] pwr_o,
    output logic                    ovf_o
);
    localparam int PRW = SW + BW + PWR_W;

    logic [SW-1:0]  mag;
    logic [PRW-1:0] prod;
    logic [PRW-1:0] lim;

    always_comb begin
        mag  = cur_i[SW-1] ? (~cur_i + 1'b1) : cur_i;
        prod = {{(PRW-SW){1'b0}}, mag} * {{(PRW-BW){1'b0}}, bus_i};
        lim  = {{(PRW-PWR_W){1'b0}}, {PWR_W{1'b1}}};
        if (prod > lim) begin
            pwr_o = {PWR_W{1'b1}};
            ovf_o = 1'b1;
        end else begin
            pwr_o = prod[PWR_W-1:0];
            ovf_o = 1'b0;
        end
    end
endmodule

// File: rtl/cpc_calc.sv
module cpc_calc #(
    parameter int SW    = 12,
    parameter int BW    = 11,
    parameter int CW    = 15,
    parameter int OUT_W = 16,
    parameter int PWR_W = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic signed [SW-1:0] shunt_i,
    input  logic        [BW-1:0] bus_i,
    input  logic        [CW-1:0] cal_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [OUT_W-1:0]     cur_o,
    output logic [PWR_W-1:0]     pwr_o,
    output logic                 ovf_o
);
    import cpc_pkg::*;

    localparam int PAD = OUT_W - SW;

    typedef struct packed {
        cpc_state_e         st;
        logic signed [SW-1:0] shunt;
        logic [BW-1:0]      bus;
        logic [CW-1:0]      cal;
        logic signed [SW-1:0] cur_tmp;
        logic               cur_ovf;
        logic signed [SW-1:0] cur;
        logic [PWR_W-1:0]   pwr;
        logic               ovf;
        logic               done;
    } cpc_regs_t;

    cpc_regs_t r_d, r_q;

    logic signed [SW-1:0] cu_cur;
    logic                 cu_ovf;
    logic [PWR_W-1:0]     pu_pwr;
    logic                 pu_ovf;

    cpc_cur_unit #(.SW(SW), .CW(CW)) u_cur (
        .shunt_i (r_q.shunt),
        .cal_i   (r_q.cal),
        .cur_o   (cu_cur),
        .ovf_o   (cu_ovf)
    );

    cpc_pwr_unit #(.SW(SW), .BW(BW), .PWR_W(PWR_W)) u_pwr (
        .cur_i (r_q.cur_tmp),
        .bus_i (r_q.bus),
        .pwr_o (pu_pwr),
        .ovf_o (pu_ovf)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.shunt = shunt_i;
                    r_d.bus   = bus_i;
                    r_d.cal   = cal_i;
                    r_d.st    = ST_CUR;
                end
            end
            ST_CUR: begin
                r_d.cur_tmp = cu_cur;
                r_d.cur_ovf = cu_ovf;
                r_d.st      = ST_PWR;
            end
            ST_PWR: begin
                r_d.cur  = r_q.cur_tmp;
                r_d.pwr  = pu_pwr;
                r_d.ovf  = r_q.cur_ovf | pu_ovf;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    generate
        if (PAD > 0) begin : g_pad
            assign cur_o = {r_q.cur, {PAD{1'b0}}};
        end else begin : g_nopad
            assign cur_o = r_q.cur;
        end
    endgenerate

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign pwr_o  = r_q.pwr;
    assign ovf_o  = r_q.ovf;
endmodule

// File: rtl/cpc_calc_chk.sv
module cpc_calc_chk #(
    parameter int OUT_W = 16,
    parameter int PWR_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OUT_W-1:0] cur_o,
    input logic [PWR_W-1:0] pwr_o,
    input logic             ovf_o
);
    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |=> (!busy_o && done_o));

    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(cur_o) && $stable(pwr_o) && $stable(ovf_o)));

    p_zero_pwr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && cur_o == '0) |-> (pwr_o == '0));
endmodule

bind cpc_calc cpc_calc_chk #(.OUT_W(OUT_W), .PWR_W(PWR_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cur_o   (cur_o),
    .pwr_o   (pwr_o),
    .ovf_o   (ovf_o)
);

// File: tb/cpc_calc_tb_top.sv
module cpc_calc_tb_top;
    logic               clk_i = 1'b0;
    logic               rst_ni = 1'b0;
    logic               start_i = 1'b0;
    logic signed [11:0] shunt_i = '0;
    logic [10:0]        bus_i = '0;
    logic [14:0]        cal_i = '0;
    logic               busy_o, done_o, ovf_o;
    logic [15:0]        cur_o, pwr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk_i = ~clk_i;

    cpc_calc dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .shunt_i(shunt_i), .bus_i(bus_i), .cal_i(cal_i),
        .busy_o(busy_o), .done_o(done_o),
        .cur_o(cur_o), .pwr_o(pwr_o), .ovf_o(ovf_o)
    );

    function automatic int exp_cur(int s, int c, output bit ov);
        longint p = longint'(s) * longint'(c);
        ov = 1'b0;
        if (p > 2047) begin ov = 1'b1; return 2047; end
        if (p < -2048) begin ov = 1'b1; return -2048; end
        return int'(p);
    endfunction

    function automatic int exp_pwr(int cur, int b, output bit ov);
        longint m = (cur < 0) ? -longint'(cur) : longint'(cur);
        longint p = m * longint'(b);
        ov = 1'b0;
        if (p > 65535) begin ov = 1'b1; return 65535; end
        return int'(p);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // Drive one computation and check timing and results.
    // poke: 1 = pulse start again and scramble operands while busy (R8)
    task automatic run(int s, int b, int c, bit poke);
        bit ovc, ovp;
        int ec, ep;
        logic [15:0] ecf;
        ec  = exp_cur(s, c, ovc);
        ep  = exp_pwr(ec, b, ovp);
        ecf = 16'(ec) << 4;
        @(negedge clk_i);
        shunt_i = 12'(s); bus_i = 11'(b); cal_i = 15'(c); start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R2", "busy after start", int'(busy_o), 1);
        chk("R10", "done low while busy", int'(done_o), 0);
        if (poke) begin
            start_i = 1'b1;
            shunt_i = ~shunt_i; bus_i = ~bus_i; cal_i = ~cal_i;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R2", "busy second cycle", int'(busy_o), 1);
        chk("R2", "done not early", int'(done_o), 0);
        @(negedge clk_i);
        chk("R2", "done pulse", int'(done_o), 1);
        chk("R2", "busy low at done", int'(busy_o), 0);
        chk("R3", "current field", int'(cur_o), int'(ecf));
        chk("R5", "power", int'(pwr_o), ep);
        chk("R7", "overflow flag", int'(ovf_o), int'(ovc | ovp));
        @(negedge clk_i);
        chk("R8", "done single / no restart", int'(done_o), 0);
        chk("R8", "idle after done", int'(busy_o), 0);
        chk("R10", "current held", int'(cur_o), int'(ecf));
        chk("R10", "power held", int'(pwr_o), ep);
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk_i);
        chk("R1", "reset cur", int'(cur_o), 0);
        chk("R1", "reset pwr", int'(pwr_o), 0);
        chk("R1", "reset ovf", int'(ovf_o), 0);
        chk("R1", "reset busy", int'(busy_o), 0);
        chk("R1", "reset done", int'(done_o), 0);
        rst_ni = 1'b1;
        // R9: zero calibration
        run(1500, 2000, 0, 1'b0);
        chk("R9", "zero cal current", int'(cur_o), 0);
        chk("R9", "zero cal ovf", int'(ovf_o), 0);
        // R3 in-range
        run(100, 50, 3, 1'b0);
        run(-7, 1000, 5, 1'b0);                 // R5 negative current
        chk("R5", "neg current power", int'(pwr_o), 35000);
        run(-2048, 1, 1, 1'b0);                 // exact minimum, no overflow
        chk("R3", "min no ovf", int'(ovf_o), 0);
        run(2047, 32, 1, 1'b0);                 // exact maximum, power 65504
        chk("R6", "power just below clamp", int'(ovf_o), 0);
        // R4 clamps
        run(-2048, 5, 2, 1'b0);
        chk("R4", "neg clamp ovf", int'(ovf_o), 1);
        run(1, 10, 32767, 1'b0);
        chk("R4", "pos clamp cur", int'(cur_o), 16'h7FF0);
        // R6 power clamp
        run(2047, 2047, 1, 1'b0);
        chk("R6", "power clamp", int'(pwr_o), 65535);
        // R7 clear after good run
        run(3, 4, 5, 1'b0);
        chk("R7", "ovf cleared", int'(ovf_o), 0);
        // R8 start and operand changes while busy
        run(20, 30, 2, 1'b1);
        run(-2048, 2047, 32767, 1'b1);
        // random
        for (int i = 0; i < 300; i++) begin
            int s, b, c;
            s = int'($signed(12'($urandom)));
            b = int'($urandom_range(0, 2047));
            c = (i % 2 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 32767));
            run(s, b, c, ($urandom_range(0, 3) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule